// File: doc/BRIEF.md
# I2C Byte-Addressed Memory Slave

This block is the serial front end of a 2 KB byte-addressed memory that sits on a two-wire I2C bus. The block runs on a system clock. It oversamples the bus clock and data lines through synchronizers and finds START and STOP conditions in the sampled stream. After a START it decodes a select byte and answers with an acknowledge when the byte matches. It then stores bytes at an 11-bit address, or it returns bytes from that address. The storage is an internal register array.

The select byte has no chip-select field. Its fixed upper nibble identifies the device. Its next three bits are the top three bits of the byte address, so the block answers to eight select codes. The last bit chooses between reading and writing. A write carries one low address byte and then data bytes. A read returns bytes from the current address, either directly or after a dummy write that sets the address, followed by a repeated START. The block only ever pulls the data line low, through an active-low output enable. The master sets the pace of the bus, and the block has no back-pressure of its own: it never holds the clock low. Every bus phase must last several system clock cycles so that the synchronizers can follow it.

Top module: `i2c_mem_slave`

## Requirements
- R1: Before the first START after reset, the block never pulls SDA low, even when a valid select byte is clocked in.
- R2: A STOP (SDA rising while SCL is high) returns the block to idle, and SDA is released.
- R3: The output enable changes only while SCL is low. SDA transitions while SCL is high are taken as START or STOP and never as data.
- R4: A select byte whose bits 7..4 differ from 1010 is not acknowledged, and the block stays silent until the next START.
- R5: Bits 3..1 of the select byte are address bits a10..a8. All eight values are accepted, and each selects its own 256-byte region.
- R6: The block acknowledges a matching select byte, a low address byte and every write data byte by holding SDA low for the ninth SCL clock.
- R7: In a write (select bit 0 = 0), the byte after the select byte gives a7..a0. Each following data byte is stored at {a10..a8, a7..a0}, and the address then increments by one.
- R8: In a read (select bit 0 = 1), the byte at the current address is shifted out MSB first. When the master sends ACK, the next byte follows from the address plus one, and the address wraps from 2047 to 0.
- R9: When the master answers a read byte with NACK (SDA high on the ninth clock), SDA is released and stays released until the next START or STOP.
- R10: A START that arrives during a transfer abandons the byte in progress without storing it, and decoding restarts at the select byte. This makes a dummy-write random read possible.
- R11: A read that has no preceding address phase uses a10..a8 from its select byte and the low address bits left by the previous access. The previous access leaves the address one past the last byte it wrote or sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_oe_n_o | output | 1 | Active-low enable of the pull-down driver; 0 pulls SDA low |

## Verification
The hardest situation to reach is a START that arrives in the middle of a byte. A write data byte is cut off after four bits, and the bench then reads the same location to show that nothing was stored. The address wrap is also hard to reach: it needs a multi-byte write, and then a long acknowledged read, that both cross 2047 to 0. The silent state after a rejected select byte is reached by clocking a valid select byte with no new START in between. The silent state before the first START is reached the same way.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int ADDR_W = 11;
  localparam int SYNC_STAGES = 2;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_TX, S_RACK, S_HOLD
  } slv_state_t;

  typedef enum logic [1:0] {
    K_DEV, K_ALO, K_DAT
  } rx_kind_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_cond.sv
module i2c_bus_cond (
  input  logic scl_lvl,
  input  logic scl_prev,
  input  logic sda_lvl,
  input  logic sda_prev,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_held_high;

  always_comb begin
    scl_held_high = scl_lvl & scl_prev;
    start_det     = scl_held_high & sda_prev & ~sda_lvl;
    stop_det      = scl_held_high & ~sda_prev & sda_lvl;
    scl_rise      = scl_lvl & ~scl_prev;
    scl_fall      = ~scl_lvl & scl_prev;
  end
endmodule

// File: rtl/i2c_byte_mem.sv
module i2c_byte_mem #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk)
    if (wr_en) cells[wr_addr] <= wr_data;

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = i2c_mem_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              pull_low
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  slv_state_t  st;
  rx_kind_t    kind;
  logic [2:0]  cnt;
  logic [6:0]  rx_sh;
  logic [7:0]  tx_sh;
  logic        go_tx;
  logic        phase;
  logic [7:0]  rx_byte;

  assign rx_byte = {rx_sh, sda_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_DEV;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      go_tx    <= 1'b0;
      phase    <= 1'b0;
      cur_addr <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      pull_low <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        st       <= S_IDLE;
        pull_low <= 1'b0;
        phase    <= 1'b0;
      end else if (start_det) begin
        st       <= S_RX;
        kind     <= K_DEV;
        cnt      <= '0;
        phase    <= 1'b0;
        pull_low <= 1'b0;
      end else begin
        unique case (st)
          S_RX: if (scl_rise) begin
            rx_sh <= rx_byte[6:0];
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              phase <= 1'b0;
              unique case (kind)
                K_DEV: begin
                  if (rx_byte[7:4] == DEV_CODE) begin
                    cur_addr <= {rx_byte[HI_W:1], cur_addr[7:0]};
                    go_tx    <= rx_byte[0];
                    kind     <= K_ALO;
                    st       <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                K_ALO: begin
                  cur_addr <= {cur_addr[ADDR_W-1:8], rx_byte};
                  kind     <= K_DAT;
                  go_tx    <= 1'b0;
                  st       <= S_ACK;
                end
                default: begin
                  wr_en    <= 1'b1;
                  wr_addr  <= cur_addr;
                  wr_data  <= rx_byte;
                  cur_addr <= cur_addr + ADDR_ONE;
                  go_tx    <= 1'b0;
                  st       <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: if (scl_fall) begin
            if (!phase) begin
              pull_low <= 1'b1;
              phase    <= 1'b1;
            end else begin
              phase <= 1'b0;
              cnt   <= '0;
              if (go_tx) begin
                tx_sh    <= rd_data;
                pull_low <= ~rd_data[7];
                st       <= S_TX;
              end else begin
                pull_low <= 1'b0;
                st       <= S_RX;
              end
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == 3'd7) begin
              pull_low <= 1'b0;
              cur_addr <= cur_addr + ADDR_ONE;
              phase    <= 1'b0;
              st       <= S_RACK;
            end else begin
              tx_sh    <= {tx_sh[6:0], 1'b0};
              pull_low <= ~tx_sh[6];
              cnt      <= cnt + 3'd1;
            end
          end
          S_RACK: begin
            if (scl_rise && !phase) begin
              if (sda_lvl) st    <= S_HOLD;
              else         phase <= 1'b1;
            end else if (scl_fall && phase) begin
              phase    <= 1'b0;
              cnt      <= '0;
              tx_sh    <= rd_data;
              pull_low <= ~rd_data[7];
              st       <= S_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: a STOP always ends in idle with the line released
  assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !pull_low));

  // R10: any START restarts select-byte decoding from bit 0
  assert_start_decodes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st == S_RX && kind == K_DEV && cnt == 3'd0 && !pull_low));

  // R3: the driver only moves while SCL is low, except when a bus condition forces release
  assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pull_low) && !$past(start_det || stop_det)) |-> !scl_lvl);

  // R4: an idle slave never drives the line
  assert_idle_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !pull_low);

  // R9: after a NACK the line stays released
  assert_hold_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD) |-> !pull_low);
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = i2c_mem_pkg::ADDR_W,
  parameter int SYNC_STAGES = i2c_mem_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_n_o
);
  logic scl_lvl, scl_prev, sda_lvl, sda_prev;
  logic start_det, stop_det, scl_rise, scl_fall;
  logic [ADDR_W-1:0] cur_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic wr_en, pull_low;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .lvl(scl_lvl), .prev(scl_prev));

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .lvl(sda_lvl), .prev(sda_prev));

  i2c_bus_cond u_cond (
    .scl_lvl(scl_lvl), .scl_prev(scl_prev), .sda_lvl(sda_lvl), .sda_prev(sda_prev),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall));

  i2c_byte_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(cur_addr), .rd_data(rd_data));

  i2c_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .rd_data(rd_data), .cur_addr(cur_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pull_low(pull_low));

  assign sda_oe_n_o = ~pull_low;
endmodule

// File: tb/tb_i2c_mem_slave.sv
module tb_i2c_mem_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe_n;
  wire  sda_bus = m_sda & sda_oe_n;

  int n_total = 0;
  int n_fail  = 0;
  int r3_viol = 0;
  bit done    = 1'b0;
  logic [7:0] model [0:2047];

  always #5 clk = ~clk;

  i2c_mem_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
                     .sda_oe_n_o(sda_oe_n));

  logic prev_scl = 1'b1, prev_oe = 1'b1;
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && (sda_oe_n != prev_oe)) r3_viol++;
    prev_scl = m_scl;
    prev_oe  = sda_oe_n;
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 13) + (a >> 8) * 5 + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wclk(4);
    m_scl = 1'b1; wclk(8);
    m_sda = 1'b0; wclk(8);
    m_scl = 1'b0; wclk(4);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wclk(4);
    m_scl = 1'b1; wclk(8);
    m_sda = 1'b1; wclk(8);
  endtask

  task automatic send_bit(bit b);
    m_sda = b; wclk(4);
    m_scl = 1'b1; wclk(8);
    m_scl = 1'b0; wclk(4);
  endtask

  task automatic recv_bit(output bit b);
    m_sda = 1'b1; wclk(4);
    m_scl = 1'b1; wclk(4);
    b = sda_bus; wclk(4);
    m_scl = 1'b0; wclk(4);
  endtask

  task automatic send_byte(logic [7:0] d, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] d);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  function automatic logic [7:0] sel(int a, bit rd);
    return 8'hA0 | 8'(((a >> 8) & 7) << 1) | 8'(rd);
  endfunction

  task automatic set_addr(int a);
    bit ak;
    i2c_start();
    send_byte(sel(a, 1'b0), ak);
    chk(ak, "R5 select ack", ak, 1);
    send_byte(8'(a & 8'hFF), ak);
    chk(ak, "R6 low address ack", ak, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] d;
    int a;
    int los [5] = '{0, 1, 5, 8'h5A, 8'hFF};

    wclk(5);
    chk(sda_oe_n === 1'b1, "R2 reset released", sda_oe_n, 1);
    rst_n = 1'b1;
    wclk(5);

    // R1: valid select byte without any START is ignored
    m_scl = 1'b0; wclk(4);
    send_byte(8'hA0, ak);
    chk(!ak, "R1 no ack before START", ak, 0);
    i2c_stop();

    // R5 R6 R7: one byte write into every region
    for (int hi = 0; hi < 8; hi++) begin
      foreach (los[k]) begin
        a = hi * 256 + los[k];
        set_addr(a);
        send_byte(pat(a), ak);
        chk(ak, "R6 data ack", ak, 1);
        model[a] = pat(a);
        i2c_stop();
      end
    end

    // R7 R10: random read-back of every written byte
    for (int hi = 0; hi < 8; hi++) begin
      foreach (los[k]) begin
        a = hi * 256 + los[k];
        set_addr(a);
        i2c_start();
        send_byte(sel(a, 1'b1), ak);
        chk(ak, "R10 read select ack", ak, 1);
        recv_byte(1'b0, d);
        chk(d === model[a], "R7 stored byte", d, model[a]);
        i2c_stop();
      end
    end

    // R7: multi-byte write across the top of the array
    set_addr(2040);
    for (int i = 0; i < 13; i++) begin
      a = (2040 + i) % 2048;
      send_byte(pat(a) ^ 8'h3C, ak);
      chk(ak, "R7 burst write ack", ak, 1);
      model[a] = pat(a) ^ 8'h3C;
    end
    i2c_stop();

    // R8: sequential read with wrap 2047 -> 0
    set_addr(2040);
    i2c_start();
    send_byte(sel(2040, 1'b1), ak);
    chk(ak, "R8 read select ack", ak, 1);
    for (int i = 0; i < 13; i++) begin
      a = (2040 + i) % 2048;
      recv_byte(i != 12, d);
      chk(d === model[a], "R8 sequential wrap read", d, model[a]);
    end
    i2c_stop();

    // R11: current-address read continues at address 5
    i2c_start();
    send_byte(sel(0, 1'b1), ak);
    chk(ak, "R11 select ack", ak, 1);
    recv_byte(1'b0, d);
    chk(d === model[5], "R11 current address byte", d, model[5]);
    // R9: after NACK the line stays released
    recv_byte(1'b0, d);
    chk(d === 8'hFF, "R9 released after NACK", d, 8'hFF);
    i2c_stop();

    // R4: wrong device nibble is not acknowledged and stays silent
    for (int nib = 0; nib < 16; nib++) begin
      if (nib == 10) continue;
      i2c_start();
      send_byte(8'(nib << 4), ak);
      chk(!ak, "R4 wrong nibble no ack", ak, 0);
      send_byte(8'hA0, ak);
      chk(!ak, "R4 silent until START", ak, 0);
      i2c_stop();
    end

    // R10: START in the middle of a data byte aborts it
    set_addr(1);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    i2c_start();
    send_byte(sel(1, 1'b1), ak);
    chk(ak, "R10 restart select ack", ak, 1);
    recv_byte(1'b0, d);
    chk(d === model[1], "R10 aborted byte not stored", d, model[1]);
    i2c_stop();

    // R2: after STOP a bare read select byte is ignored
    send_byte(sel(0, 1'b1), ak);
    chk(!ak, "R2 idle after STOP", ak, 0);
    i2c_stop();

    chk(r3_viol == 0, "R3 drive changes only with SCL low", r3_viol, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule